// File: doc/BRIEF.md
# Three-State Sequenced Counter with Bit-Tracking and Done Flags

This block is a small controller paired with a register-transfer datapath. The controller is an algorithmic state machine with three states: idle, run and finish. It holds its state in two D flip-flops. A binary decoder turns the state code into one-hot state lines. The next-state equations are written by hand from the transition rules. The datapath holds a 4-bit counter, a tracking flag and a done flag. Each register operation is enabled by a decoded state line, and some are also gated by a condition.

A one-cycle high level on `start` while idle clears the counter and the done flag and enters the run state. In the run state the counter advances by one on every clock. On each of those clocks the tracking flag copies counter bit 1. The machine leaves the run state when counter bits 1 and 2 are both high. Every decision in a state uses the register values held before that clock edge. All operations of a state take effect together on that edge. The finish state raises the done flag and returns to idle on the next clock.

Top module: `asm_flag_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next outputs are `state_code`=00, `cnt`=0, `e_flag`=0 and `f_flag`=0.
- R2: In idle (`state_code`=00) with `start`=0, the edge leaves `state_code`, `cnt`, `e_flag` and `f_flag` unchanged.
- R3: In idle with `start`=1, the edge sets `cnt` to 0, `f_flag` to 0 and `state_code` to 01, and leaves `e_flag` unchanged.
- R4: In run (`state_code`=01), every edge sets `cnt` to the previous `cnt` plus one, modulo 16. `f_flag` does not change.
- R5: In run, every edge loads `e_flag` with the value that `cnt[1]` held before that edge.
- R6: In run, the next state is finish (`state_code`=11) when `cnt[1]` and `cnt[2]` were both 1 before the edge. Otherwise the state stays 01.
- R7: In finish (`state_code`=11), the edge sets `f_flag` to 1 and `state_code` to 00, and leaves `cnt` and `e_flag` unchanged.
- R8: `state_code` never shows the unused code 10. If the state flops ever hold 10, they return to 00 on the next edge and enable no register operation. At most one decoded state line is active at a time.
- R9: A one-cycle `start` pulse from idle gives exactly seven cycles with `state_code`=01. After that come one finish cycle and a return to idle with `cnt`=7, `e_flag`=1 and `f_flag`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request, sampled only in idle |
| cnt | output | 4 | Counter value; bit 0 is the least significant bit |
| e_flag | output | 1 | Tracking flag, loaded from cnt[1] in run |
| f_flag | output | 1 | Done flag |
| state_code | output | 2 | State flops: 00 idle, 01 run, 11 finish |

## Verification
The main function is driven with `start` held low in idle, with single-cycle pulses, and with `start` held high continuously. Holding `start` low shows that idle really holds. Held high, an immediate restart from idle must clear the done flag set by the previous run. A random mix of `start` levels and occasional mid-run resets compares every output in every cycle against a cycle-accurate model. This catches a decision taken on post-increment values, a wrong exit bit or a wrong state code. A directed single-pulse run counts the cycles spent in run and checks the final counter value of 7, which separates the correct exit point from one clock early or late.

// File: rtl/asm_cnt_pkg.sv
package asm_cnt_pkg;
  localparam int unsigned STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_BAD  = 2'b10,
    ST_DONE = 2'b11
  } asm_state_e;
endpackage

// File: rtl/asm_decoder.sv
module asm_decoder #(
  parameter int unsigned IN_W = 2,
  localparam int unsigned OUT_N = 1 << IN_W
) (
  input  logic [IN_W-1:0]  code,
  output logic [OUT_N-1:0] line
);
  for (genvar i = 0; i < OUT_N; i++) begin : g_line
    assign line[i] = (code == IN_W'(i));
  end
endmodule

// File: rtl/asm_ctrl.sv
module asm_ctrl
  import asm_cnt_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               bit_track,
  input  logic               bit_exit,
  output logic               t_idle,
  output logic               t_run,
  output logic               t_done,
  output logic [STATE_W-1:0] state_code
);
  localparam int unsigned LINES = 1 << STATE_W;

  logic [STATE_W-1:0] g_q;
  logic [LINES-1:0]   dec_line;
  logic               d_g1, d_g0;

  asm_decoder #(.IN_W(STATE_W)) u_dec (
    .code (g_q),
    .line (dec_line)
  );

  assign t_idle = dec_line[ST_IDLE];
  assign t_run  = dec_line[ST_RUN];
  assign t_done = dec_line[ST_DONE];

  // hand-derived flop inputs for the 00/01/11 assignment
  assign d_g1 = t_run & bit_track & bit_exit;
  assign d_g0 = (t_idle & start) | t_run;

  always_ff @(posedge clk) begin
    if (rst) g_q <= ST_IDLE;
    else     g_q <= {d_g1, d_g0};
  end

  assign state_code = g_q;

  // R8: one decoded line at most, and the unused code never reached
  p_onehot_lines_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({t_idle, t_run, t_done}));
  p_no_bad_code_r8: assert property (@(posedge clk) disable iff (rst)
    !dec_line[ST_BAD]);
  // R6: run exits only on both bits high
  p_run_exit_r6: assert property (@(posedge clk) disable iff (rst)
    (t_run && bit_track && bit_exit) |=> (state_code == ST_DONE));
  p_run_stay_r6: assert property (@(posedge clk) disable iff (rst)
    (t_run && !(bit_track && bit_exit)) |=> (state_code == ST_RUN));
  // R7: finish lasts one cycle
  p_done_ret_r7: assert property (@(posedge clk) disable iff (rst)
    t_done |=> (state_code == ST_IDLE));
  // R2: idle holds without start
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (t_idle && !start) |=> (state_code == ST_IDLE));
endmodule

// File: rtl/asm_datapath.sv
module asm_datapath #(
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned TRK_IX = 1,
  parameter int unsigned EXT_IX = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             t_idle,
  input  logic             t_run,
  input  logic             t_done,
  output logic [CNT_W-1:0] cnt,
  output logic             e_flag,
  output logic             f_flag,
  output logic             bit_track,
  output logic             bit_exit
);
  logic clr_op;

  assign clr_op    = t_idle & start;
  assign bit_track = cnt[TRK_IX];
  assign bit_exit  = cnt[EXT_IX];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      e_flag <= 1'b0;
      f_flag <= 1'b0;
    end else begin
      if (clr_op) begin
        cnt    <= '0;
        f_flag <= 1'b0;
      end
      if (t_run) begin
        cnt    <= cnt + CNT_W'(1);
        e_flag <= cnt[TRK_IX];
      end
      if (t_done) f_flag <= 1'b1;
    end
  end

  // R1: reset clears the datapath
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (cnt == '0 && !e_flag && !f_flag));
  // R4: increment in run, done flag untouched
  p_run_inc_r4: assert property (@(posedge clk) disable iff (rst)
    t_run |=> (cnt == $past(cnt) + CNT_W'(1)) && $stable(f_flag));
  // R5: tracking flag takes the pre-edge bit
  p_track_r5: assert property (@(posedge clk) disable iff (rst)
    t_run |=> (e_flag == $past(cnt[TRK_IX])));
  // R3: start clears counter and done flag
  p_start_clr_r3: assert property (@(posedge clk) disable iff (rst)
    (t_idle && start) |=> (cnt == '0 && !f_flag && $stable(e_flag)));
  // R7: finish sets done, holds counter and tracking flag
  p_done_set_r7: assert property (@(posedge clk) disable iff (rst)
    t_done |=> (f_flag && $stable(cnt) && $stable(e_flag)));
  // R2: idle without start holds everything
  p_idle_keep_r2: assert property (@(posedge clk) disable iff (rst)
    (t_idle && !start) |=> ($stable(cnt) && $stable(e_flag) && $stable(f_flag)));
endmodule

// File: rtl/asm_flag_counter.sv
module asm_flag_counter
  import asm_cnt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  output logic [3:0] cnt,
  output logic       e_flag,
  output logic       f_flag,
  output logic [1:0] state_code
);
  logic t_idle, t_run, t_done;
  logic bit_track, bit_exit;

  asm_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .bit_track  (bit_track),
    .bit_exit   (bit_exit),
    .t_idle     (t_idle),
    .t_run      (t_run),
    .t_done     (t_done),
    .state_code (state_code)
  );

  asm_datapath #(.CNT_W(4), .TRK_IX(1), .EXT_IX(2)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .t_idle    (t_idle),
    .t_run     (t_run),
    .t_done    (t_done),
    .cnt       (cnt),
    .e_flag    (e_flag),
    .f_flag    (f_flag),
    .bit_track (bit_track),
    .bit_exit  (bit_exit)
  );

  // R8: visible code stays within the three used values
  p_code_legal_r8: assert property (@(posedge clk) disable iff (rst)
    state_code != 2'b10);
endmodule

// File: tb/sim_asm_flag_counter.sv
module sim_asm_flag_counter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [3:0] cnt;
  logic       e_flag, f_flag;
  logic [1:0] state_code;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // reference model state
  logic [1:0] m_st = 2'b00;
  logic [3:0] m_a = 4'd0;
  logic       m_e = 1'b0;
  logic       m_f = 1'b0;
  string      tag = "R1";

  always #5 clk = ~clk;

  asm_flag_counter u0 (
    .clk(clk), .rst(rst), .start(start),
    .cnt(cnt), .e_flag(e_flag), .f_flag(f_flag), .state_code(state_code)
  );

  function automatic string tag_for(logic r, logic [1:0] st, logic s);
    if (r) return "R1";
    case (st)
      2'b00:   return s ? "R3" : "R2";
      2'b01:   return "R4/R5/R6";
      2'b11:   return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  // model step for the coming edge
  task automatic model_step(logic r, logic s);
    logic [1:0] nst;
    logic [3:0] na;
    logic ne, nf;
    tag = tag_for(r, m_st, s);
    nst = m_st; na = m_a; ne = m_e; nf = m_f;
    if (r) begin
      nst = 2'b00; na = 0; ne = 0; nf = 0;
    end else begin
      case (m_st)
        2'b00: if (s) begin na = 0; nf = 0; nst = 2'b01; end
        2'b01: begin
          na = m_a + 4'd1;
          ne = m_a[1];
          nst = (m_a[1] && m_a[2]) ? 2'b11 : 2'b01;
        end
        2'b11: begin nf = 1'b1; nst = 2'b00; end
        default: nst = 2'b00;
      endcase
    end
    m_st = nst; m_a = na; m_e = ne; m_f = nf;
  endtask

  task automatic compare_all();
    check(tag, "state_code", state_code, m_st);
    check(tag, "cnt", cnt, m_a);
    check(tag, "e_flag", e_flag, m_e);
    check(tag, "f_flag", f_flag, m_f);
    if (state_code == 2'b10) check("R8", "illegal code", 1, 0);
  endtask

  // one cycle: check at negedge, drive, advance the model
  task automatic cycle(logic r, logic s);
    @(negedge clk);
    compare_all();
    rst = r; start = s;
    model_step(r, s);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int run_cycles;
    void'($urandom(32'd4242));
    model_step(1'b1, 1'b0);
    // R1: reset with start high must still clear
    cycle(1'b1, 1'b1);
    cycle(1'b1, 1'b0);
    cycle(1'b0, 1'b0);
    // R2: start held low in idle
    for (int i = 0; i < 20; i++) cycle(1'b0, 1'b0);
    // R9: single-cycle pulse, count the run cycles
    cycle(1'b0, 1'b1);
    run_cycles = 0;
    for (int i = 0; i < 12; i++) begin
      cycle(1'b0, 1'b0);
      if (state_code == 2'b01) run_cycles++;
    end
    check("R9", "run cycles", run_cycles, 7);
    check("R9", "final cnt", cnt, 7);
    check("R9", "final f_flag", f_flag, 1);
    check("R9", "final e_flag", e_flag, 1);
    check("R9", "final state", state_code, 0);
    // R3: start held high, back-to-back restarts clear the done flag
    for (int i = 0; i < 40; i++) cycle(1'b0, 1'b1);
    // reset in the middle of a run
    cycle(1'b0, 1'b0);
    cycle(1'b0, 1'b1);
    cycle(1'b0, 1'b0);
    cycle(1'b0, 1'b0);
    cycle(1'b1, 1'b0);
    cycle(1'b0, 1'b0);
    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      logic r, s;
      r = ($urandom_range(0, 99) == 0);
      s = ($urandom_range(0, 3) == 0);
      cycle(r, s);
    end
    @(negedge clk);
    compare_all();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule